// File: doc/BRIEF.md
# Registered Skid Buffer Stage

This block is one pipeline stage placed between a producer and a consumer that talk through a strobe/stall handshake. The producer raises `up_vld` with a word on `up_data` and holds back while `up_stall` is high; the consumer sees `dn_vld` and `dn_data` and raises `dn_stall` when it cannot take a word. Every output of the stage comes from a flop, so neither the forward data path nor the backward stall path carries any combinational logic from one side to the other.

Because the stall seen by the producer is registered, it arrives one cycle late. A word the producer offers in that cycle would be lost if the stage had nowhere to put it. The stage therefore keeps one side register. When the consumer stalls while a word is already on the output, one more incoming word lands in that side register, and the stage then raises its stall. When the consumer frees up, the side word moves onto the output and the stall drops. The side register holds the only state that the stall flag records. It loads the input on every cycle in which it is empty, so its data path needs no enable derived from the strobe.

Top module: `skid_stage`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `dn_vld` and `up_stall` are 0.
- R2: With `up_stall` low and `dn_stall` low, on the next cycle `dn_vld` equals the previous `up_vld`, and if that was 1, `dn_data` equals the previous `up_data`.
- R3: While `dn_vld` and `dn_stall` are both high, on the next cycle `dn_vld` stays high and `dn_data` is unchanged.
- R4: With `dn_stall` high and `dn_vld` low, a strobed input is loaded onto the output on the next cycle, and `up_stall` stays low.
- R5: With `dn_stall` high, `dn_vld` high, `up_stall` low and `up_vld` high, the input is caught in the side register: on the next cycle `up_stall` is 1 and `dn_data` is unchanged.
- R6: With `up_stall` high and `dn_stall` low, on the next cycle `dn_vld` is 1, `dn_data` is the word caught in the side register, and `up_stall` is 0.
- R7: `up_stall` is high only while `dn_vld` is high, and a new word is always accepted while `up_stall` is low.
- R8: A word enters on a cycle with `up_vld && !up_stall` and leaves on a cycle with `dn_vld && !dn_stall`. Words leave in the order they entered, with no loss and no duplication under any stall pattern.
- R9: While `up_stall` is high, `up_vld` and `up_data` have no effect: the word held in the side register is the one later presented on `dn_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| up_vld | input | 1 | Producer offers a word |
| up_data | input | DATA_W | Producer word |
| up_stall | output | 1 | Stage cannot accept; high exactly when the side register is full |
| dn_vld | output | 1 | Output word is valid |
| dn_data | output | DATA_W | Output word |
| dn_stall | input | 1 | Consumer cannot take the output word this cycle |

## Verification
The bench pushes a stream of numbered words through long full stalls, free running, strict alternation and random strobe/stall patterns. It tracks the stage's occupancy in a queue, so it knows on every cycle what the output and the stall flag must show. The hard cases are an input that arrives in the cycle before the registered stall rises, and a stall release while the side register is full. A design that dropped the first would skip a sequence number. One that released the side word late, or let the producer overwrite it, would repeat a word or show the poisoned value the bench drives while stalled. The bench also catches output words that change under a stall, and an output register overwritten on the capture path.

// File: rtl/skid_pkg.sv
package skid_pkg;

  // Source selected for the output data register on the coming edge.
  typedef enum logic [1:0] {
    OUT_HOLD      = 2'd0,
    OUT_FROM_IN   = 2'd1,
    OUT_FROM_SIDE = 2'd2
  } out_sel_e;

endpackage

// File: rtl/skid_dreg.sv
module skid_dreg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  // Data holds no reset: its validity is tracked by the control flops.
  always_ff @(posedge clk) begin
    q <= q_nxt;
  end

endmodule

// File: rtl/skid_ctrl.sv
module skid_ctrl
  import skid_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     up_vld,
  input  logic     dn_stall,
  output logic     vld_q,
  output logic     full_q,
  output out_sel_e out_sel,
  output logic     side_en
);

  logic vld_nxt;
  logic full_nxt;

  // Strict priority: consumer free, then output empty, then capture.
  always_comb begin
    vld_nxt  = vld_q;
    full_nxt = full_q;
    out_sel  = OUT_HOLD;
    if (!dn_stall) begin
      if (full_q) begin
        vld_nxt  = 1'b1;
        full_nxt = 1'b0;
        out_sel  = OUT_FROM_SIDE;
      end else begin
        vld_nxt = up_vld;
        if (up_vld) out_sel = OUT_FROM_IN;
      end
    end else if (!vld_q) begin
      vld_nxt = up_vld;
      if (up_vld) out_sel = OUT_FROM_IN;
    end else if (up_vld && !full_q) begin
      full_nxt = 1'b1;
    end
  end

  // Side register follows the input whenever it holds nothing.
  assign side_en = !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      vld_q  <= vld_nxt;
      full_q <= full_nxt;
    end
  end

endmodule

// File: rtl/skid_stage.sv
module skid_stage
  import skid_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_vld,
  input  logic [DATA_W-1:0] up_data,
  output logic              up_stall,
  output logic              dn_vld,
  output logic [DATA_W-1:0] dn_data,
  input  logic              dn_stall
);

  out_sel_e          out_sel;
  logic              side_en;
  logic              full_q;
  logic              vld_q;
  logic              out_en;
  logic [DATA_W-1:0] side_q;
  logic [DATA_W-1:0] out_d;
  logic [DATA_W-1:0] out_q;

  skid_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_vld   (up_vld),
    .dn_stall (dn_stall),
    .vld_q    (vld_q),
    .full_q   (full_q),
    .out_sel  (out_sel),
    .side_en  (side_en)
  );

  skid_dreg #(.WIDTH(DATA_W)) u_side (
    .clk (clk),
    .en  (side_en),
    .d   (up_data),
    .q   (side_q)
  );

  always_comb begin
    out_en = (out_sel != OUT_HOLD);
    out_d  = (out_sel == OUT_FROM_SIDE) ? side_q : up_data;
  end

  skid_dreg #(.WIDTH(DATA_W)) u_out (
    .clk (clk),
    .en  (out_en),
    .d   (out_d),
    .q   (out_q)
  );

  assign up_stall = full_q;
  assign dn_vld   = vld_q;
  assign dn_data  = out_q;

endmodule

// File: rtl/skid_stage_chk.sv
module skid_stage_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_vld,
  input logic [DATA_W-1:0] up_data,
  input logic              up_stall,
  input logic              dn_vld,
  input logic [DATA_W-1:0] dn_data,
  input logic              dn_stall
);

  // R2: free path loads the output from the input
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_stall && !dn_stall && up_vld) |=> (dn_vld && dn_data == $past(up_data)));

  // R3: output word frozen while consumer stalls
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_vld && dn_stall) |=> (dn_vld && $stable(dn_data)));

  // R4: empty output fills even under a stall
  p_fill_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_stall && !dn_vld && up_vld) |=> (dn_vld && !up_stall && dn_data == $past(up_data)));

  // R5: extra word goes to the side register
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_stall && dn_vld && up_vld && !up_stall) |=> up_stall);

  // R6: side word drains once the consumer frees up
  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_stall && !dn_stall) |=> (dn_vld && !up_stall));

  // R7: a full side register implies an occupied output
  p_stall_needs_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    up_stall |-> dn_vld);

endmodule

bind skid_stage skid_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .up_vld   (up_vld),
  .up_data  (up_data),
  .up_stall (up_stall),
  .dn_vld   (dn_vld),
  .dn_data  (dn_data),
  .dn_stall (dn_stall)
);

// File: tb/skid_stage_tb.sv
module skid_stage_tb;

  localparam int DATA_W = 16;
  localparam int NRAND  = 3000;

  logic              clk;
  logic              rst_n;
  logic              up_vld;
  logic [DATA_W-1:0] up_data;
  logic              up_stall;
  logic              dn_vld;
  logic [DATA_W-1:0] dn_data;
  logic              dn_stall;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  skid_stage #(.DATA_W(DATA_W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_vld   (up_vld),
    .up_data  (up_data),
    .up_stall (up_stall),
    .dn_vld   (dn_vld),
    .dn_data  (dn_data),
    .dn_stall (dn_stall)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Reference: the words currently held by the stage, oldest first.
  logic [DATA_W-1:0] model_q[$];
  int                in_seq  = 0;
  int                out_seq = 0;
  logic              prev_hold;
  logic [DATA_W-1:0] prev_data;
  string             tag_d;
  string             tag_s;

  task automatic one_cycle(input logic v, input logic s);
    int n;
    @(negedge clk);
    n = model_q.size();
    check({tag_s, " vld"}, {63'd0, dn_vld}, {63'd0, n > 0});
    check({tag_s, " stall"}, {63'd0, up_stall}, {63'd0, n == 2});
    if (n > 0) check({tag_d, " data"}, {48'd0, dn_data}, {48'd0, model_q[0]});
    if (prev_hold) check("R3 hold", {48'd0, dn_data}, {48'd0, prev_data});
    up_vld   = v;
    dn_stall = s;
    // Poisoned value while stalled: must never reach the output (R9).
    up_data  = (n == 2) ? (DATA_W'(in_seq) | {1'b1, {(DATA_W-1){1'b0}}}) : DATA_W'(in_seq);
    // Scenario tag for the checks made on the next cycle.
    if (n == 2 && !s)            begin tag_d = "R6"; tag_s = "R6"; end
    else if (n == 2)             begin tag_d = "R9"; tag_s = "R9"; end
    else if (n == 1 && s && v)   begin tag_d = "R5"; tag_s = "R5"; end
    else if (n == 1 && s)        begin tag_d = "R3"; tag_s = "R7"; end
    else if (n == 0 && s && v)   begin tag_d = "R4"; tag_s = "R4"; end
    else                         begin tag_d = "R2"; tag_s = "R7"; end
    prev_hold = dn_vld && s;
    prev_data = dn_data;
    // R8: every downstream transfer carries the next number in order.
    if (dn_vld && !s) begin
      check("R8 order", {48'd0, dn_data}, {48'd0, DATA_W'(out_seq)});
      out_seq++;
    end
    if (n > 0 && !s) void'(model_q.pop_front());
    if (v && n < 2) begin
      model_q.push_back(DATA_W'(in_seq));
      in_seq++;
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    up_vld    = 1'b0;
    up_data   = '0;
    dn_stall  = 1'b0;
    prev_hold = 1'b0;
    prev_data = '0;
    tag_d     = "R1";
    tag_s     = "R1";
    repeat (3) @(negedge clk);
    check("R1 vld in reset", {63'd0, dn_vld}, 64'd0);
    check("R1 stall in reset", {63'd0, up_stall}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 vld after release", {63'd0, dn_vld}, 64'd0);
    check("R1 stall after release", {63'd0, up_stall}, 64'd0);
    // Free running stream
    for (int i = 0; i < 40; i++) one_cycle(1'b1, 1'b0);
    // Long stall with producer pushing
    for (int i = 0; i < 30; i++) one_cycle(1'b1, 1'b1);
    // Release: side word drains
    for (int i = 0; i < 30; i++) one_cycle(1'b1, 1'b0);
    // Drain to empty, then stall from empty
    for (int i = 0; i < 5; i++) one_cycle(1'b0, 1'b0);
    for (int i = 0; i < 10; i++) one_cycle(1'b1, 1'b1);
    // Strict alternation of the stall
    for (int i = 0; i < 60; i++) one_cycle(1'b1, i[0]);
    // Alternation on both sides
    for (int i = 0; i < 60; i++) one_cycle(i[0], i[1]);
    // Random traffic
    for (int i = 0; i < NRAND; i++)
      one_cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0 ? 1 : $urandom_range(0, 1)));
    // Drain
    for (int i = 0; i < 10; i++) one_cycle(1'b0, 1'b0);
    check("R8 all delivered", 64'(out_seq), 64'(in_seq));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule